// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the device side of a transmit ring that a host shares with the hardware. The ring sits inside the block as a small array of descriptor slots. The host fills a slot through a write port: it sets an ownership flag, start and end markers and a beat count. It then strobes `wake`. The engine walks the slots in index order from where it last stopped. For every slot it owns, it streams the associated data buffer out as a sequence of beats. It then clears the ownership flag, which hands the slot back, and moves to the next index. The first slot it does not own ends the walk, and the engine waits for the next strobe.

The ring has more slots than there are data buffers. A slot's buffer number is its index with the upper bits masked off. Completions set a sticky status flag. A host-writable mask register gates that flag onto `irq`. The mask comes out of reset suppressing everything, so software can turn the interrupt on and off around its own high and low fill marks. A slot that is owned but does not carry both frame markers is not streamed. It is returned to the host and recorded in a sticky error flag.

Top module: `tx_ring_engine`

## Requirements
- R1: A descriptor is 14 bits wide. Bit 13 is the ownership flag (1 = engine owns the slot). Bit 12 marks the start of a frame. Bit 11 marks the end of a frame. Bits 10:0 hold the length in beats. `host_rd_desc` returns the slot selected by `host_rd_idx` in this same layout.
- R2: After reset the following hold: every slot reads as zero, `ring_idx` is 0, `tx_valid` is 0, both status flags are 0 and `irq` is 0.
- R3: The engine starts walking only on a `wake` pulse, beginning at `ring_idx`. An owned slot is left untouched, and no beat is sent, until `wake` arrives.
- R4: An owned slot with both frame markers and length L > 0 produces exactly L beats, with `tx_off` running 0..L-1. `tx_last` is high only on the final beat. While `tx_ready` is low, `tx_valid`, `tx_buf` and `tx_off` are held.
- R5: `tx_buf` equals the slot index ANDed with NUM_BUFS-1. With the defaults, slot 9 uses buffer 1.
- R6: When a slot's final beat is accepted, its ownership bit is cleared and its other fields are kept. `ring_idx` then advances by one and wraps from RING_SLOTS-1 to 0.
- R7: The walk stops at the first slot whose ownership bit is 0. `ring_idx` stays on that slot, and later slots are not processed until the next `wake`.
- R8: An owned slot that lacks the start marker or the end marker sends no beats. It is returned with its other fields kept, and it sets `stat_err`. It does not set `stat_done`.
- R9: An owned slot with both markers and length 0 sends no beats, is returned, and sets `stat_done`.
- R10: `stat_done` is set by every completed slot and stays set until a `stat_clr_wr` write with bit 0 of `stat_clr_bits` at 1. `stat_err` is cleared the same way through bit 1. A 0 bit leaves its flag unchanged.
- R11: `irq` is high exactly when `stat_done` is 1 and the mask register is all zeros. The mask resets to all ones, and any nonzero mask value suppresses `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host writes a descriptor slot |
| host_wr_idx | input | 4 | Slot written by the host |
| host_wr_desc | input | 14 | Descriptor word written |
| host_rd_idx | input | 4 | Slot read back by the host |
| host_rd_desc | output | 14 | Descriptor word of `host_rd_idx` |
| wake | input | 1 | Wakeup strobe, starts a walk |
| imask_wr | input | 1 | Writes the interrupt mask register |
| imask_wdata | input | 32 | Mask value, all zeros enables `irq` |
| stat_clr_wr | input | 1 | Write-one-to-clear strobe for the status flags |
| stat_clr_bits | input | 2 | Bit 0 clears done, bit 1 clears error |
| stat_done | output | 1 | Sticky completion flag |
| stat_err | output | 1 | Sticky malformed-descriptor flag |
| irq | output | 1 | Transmit completion interrupt |
| tx_valid | output | 1 | A data beat is offered |
| tx_ready | input | 1 | The sink accepts the beat |
| tx_buf | output | 3 | Buffer number of the current beat |
| tx_off | output | 11 | Beat offset within the buffer |
| tx_last | output | 1 | Final beat of the frame |
| ring_idx | output | 4 | Slot the engine is on or will resume from |

## Verification
A wrong slot index shows up on `tx_buf` on the very first beat of the affected frame. A lost ownership clear shows up on `host_rd_desc` one cycle after the final beat is accepted. A beat counter that is off by one gives a missing or extra beat, or a misplaced `tx_last`. The scoreboard catches this as soon as the frame ends. A wrong stop decision leaves `ring_idx` on the wrong slot after the walk goes quiet. A broken sticky flag or mask path appears on `stat_done`, `stat_err` or `irq` in the cycle after the triggering write or completion.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
  localparam int LEN_W  = 11;
  localparam int DESC_W = LEN_W + 3;

  typedef struct packed {
    logic             own;
    logic             sop;
    logic             eop;
    logic [LEN_W-1:0] len;
  } tx_desc_t;

  // next slot with wrap after the last one
  function automatic int unsigned slot_after(int unsigned slot, int unsigned nslots);
    return (slot == nslots - 1) ? 0 : slot + 1;
  endfunction

  // buffer chosen by masking the slot number (nbufs is a power of two)
  function automatic int unsigned slot_to_buf(int unsigned slot, int unsigned nbufs);
    return slot & (nbufs - 1);
  endfunction
endpackage

// File: rtl/txr_slot_store.sv
module txr_slot_store
  import tx_ring_pkg::*;
#(
  parameter int RING_SLOTS = 16,
  parameter int IDX_W      = $clog2(RING_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_en,
  input  logic [IDX_W-1:0] hw_idx,
  input  tx_desc_t         hw_desc,
  input  logic [IDX_W-1:0] hr_idx,
  output tx_desc_t         hr_desc,
  input  logic [IDX_W-1:0] er_idx,
  output tx_desc_t         er_desc,
  input  logic             rel_en,
  input  logic [IDX_W-1:0] rel_idx
);
  tx_desc_t slots [RING_SLOTS];

  // one register per slot; a host write wins over an engine release
  for (genvar s = 0; s < RING_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slots[s] <= '0;
      end else if (hw_en && hw_idx == IDX_W'(s)) begin
        slots[s] <= hw_desc;
      end else if (rel_en && rel_idx == IDX_W'(s)) begin
        slots[s].own <= 1'b0;
      end
    end
  end

  assign hr_desc = slots[hr_idx];
  assign er_desc = slots[er_idx];
endmodule

// File: rtl/txr_walker.sv
module txr_walker
  import tx_ring_pkg::*;
#(
  parameter int RING_SLOTS = 16,
  parameter int NUM_BUFS   = 8,
  parameter int IDX_W      = $clog2(RING_SLOTS),
  parameter int BUF_W      = $clog2(NUM_BUFS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake,
  input  tx_desc_t         cur,
  output logic [IDX_W-1:0] idx,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [BUF_W-1:0] tx_buf,
  output logic [LEN_W-1:0] tx_off,
  output logic             tx_last,
  output logic             rel_en,
  output logic             rel_ok,
  output logic             rel_bad
);
  typedef enum logic [1:0] {W_IDLE, W_SCAN, W_SEND} wstate_t;
  wstate_t          state;
  logic [LEN_W-1:0] off, len_q;
  logic             cur_ok, cur_bad, beat_fire, scan_rel;

  assign cur_ok    = cur.own && cur.sop && cur.eop;
  assign cur_bad   = cur.own && !(cur.sop && cur.eop);
  assign beat_fire = (state == W_SEND) && tx_ready;
  assign tx_valid  = (state == W_SEND);
  assign tx_last   = (state == W_SEND) && (off == len_q - LEN_W'(1));
  assign tx_off    = off;
  assign tx_buf    = BUF_W'(slot_to_buf(32'(idx), 32'(NUM_BUFS)));

  // slots returned without streaming: malformed or empty
  assign scan_rel  = (state == W_SCAN) && cur.own && (!cur_ok || cur.len == '0);
  assign rel_en    = scan_rel || (beat_fire && tx_last);
  assign rel_bad   = (state == W_SCAN) && cur_bad;
  assign rel_ok    = rel_en && !rel_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= W_IDLE;
      idx   <= '0;
      off   <= '0;
      len_q <= '0;
    end else begin
      unique case (state)
        W_IDLE: if (wake) state <= W_SCAN;
        W_SCAN: begin
          if (!cur.own) begin
            state <= W_IDLE;
          end else if (cur_ok && cur.len != '0) begin
            len_q <= cur.len;
            off   <= '0;
            state <= W_SEND;
          end else begin
            idx <= IDX_W'(slot_after(32'(idx), 32'(RING_SLOTS)));
          end
        end
        W_SEND: begin
          if (beat_fire) begin
            if (tx_last) begin
              idx   <= IDX_W'(slot_after(32'(idx), 32'(RING_SLOTS)));
              state <= W_SCAN;
            end else begin
              off <= off + LEN_W'(1);
            end
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_off) && $stable(tx_buf)); // R4
  AST_LAST_ONLY_WHEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid); // R4
  AST_STREAM_OWNED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> cur.own); // R7
  AST_IDX_MOVES_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_en |=> $stable(idx)); // R6
endmodule

// File: rtl/txr_status.sv
module txr_status #(
  parameter int MASK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_evt,
  input  logic              err_evt,
  input  logic              clr_wr,
  input  logic [1:0]        clr_bits,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_wdata,
  output logic              done,
  output logic              err,
  output logic              irq
);
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      // a new event in the same cycle beats the clear
      done <= done_evt || (done && !(clr_wr && clr_bits[0]));
      err  <= err_evt  || (err  && !(clr_wr && clr_bits[1]));
    end
  end

  assign irq = done && (mask_q == '0);

  AST_DONE_FOLLOWS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> done); // R10
  AST_ERR_FOLLOWS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> err); // R8
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clr_wr |=> done); // R10
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
  import tx_ring_pkg::*;
#(
  parameter  int RING_SLOTS = 16,
  parameter  int NUM_BUFS   = 8,
  parameter  int MASK_W     = 32,
  localparam int IDX_W      = $clog2(RING_SLOTS),
  localparam int BUF_W      = $clog2(NUM_BUFS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [IDX_W-1:0]  host_wr_idx,
  input  logic [DESC_W-1:0] host_wr_desc,
  input  logic [IDX_W-1:0]  host_rd_idx,
  output logic [DESC_W-1:0] host_rd_desc,
  input  logic              wake,
  input  logic              imask_wr,
  input  logic [MASK_W-1:0] imask_wdata,
  input  logic              stat_clr_wr,
  input  logic [1:0]        stat_clr_bits,
  output logic              stat_done,
  output logic              stat_err,
  output logic              irq,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BUF_W-1:0]  tx_buf,
  output logic [LEN_W-1:0]  tx_off,
  output logic              tx_last,
  output logic [IDX_W-1:0]  ring_idx
);
  tx_desc_t         rd_desc, eng_desc;
  logic             rel_en, rel_ok, rel_bad;
  logic [IDX_W-1:0] idx;

  txr_slot_store #(.RING_SLOTS(RING_SLOTS), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_en   (host_wr_en),
    .hw_idx  (host_wr_idx),
    .hw_desc (tx_desc_t'(host_wr_desc)),
    .hr_idx  (host_rd_idx),
    .hr_desc (rd_desc),
    .er_idx  (idx),
    .er_desc (eng_desc),
    .rel_en  (rel_en),
    .rel_idx (idx)
  );

  txr_walker #(.RING_SLOTS(RING_SLOTS), .NUM_BUFS(NUM_BUFS),
               .IDX_W(IDX_W), .BUF_W(BUF_W)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wake     (wake),
    .cur      (eng_desc),
    .idx      (idx),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_buf   (tx_buf),
    .tx_off   (tx_off),
    .tx_last  (tx_last),
    .rel_en   (rel_en),
    .rel_ok   (rel_ok),
    .rel_bad  (rel_bad)
  );

  txr_status #(.MASK_W(MASK_W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_evt   (rel_ok),
    .err_evt    (rel_bad),
    .clr_wr     (stat_clr_wr),
    .clr_bits   (stat_clr_bits),
    .mask_wr    (imask_wr),
    .mask_wdata (imask_wdata),
    .done       (stat_done),
    .err        (stat_err),
    .irq        (irq)
  );

  assign host_rd_desc = DESC_W'(rd_desc);
  assign ring_idx     = idx;

  AST_RELEASED_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en && !(host_wr_en && host_wr_idx == idx) |=> !u_store.slots[$past(idx)].own); // R6
  AST_IRQ_IMPLIES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_done); // R11
endmodule

// File: tb/tx_ring_engine_bench.sv
`timescale 1ns/1ps
module tx_ring_engine_bench;
  localparam int RING = 16;
  localparam int NB   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [3:0]  host_wr_idx = '0;
  logic [13:0] host_wr_desc = '0;
  logic [3:0]  host_rd_idx = '0;
  logic [13:0] host_rd_desc;
  logic        wake = 1'b0;
  logic        imask_wr = 1'b0;
  logic [31:0] imask_wdata = '0;
  logic        stat_clr_wr = 1'b0;
  logic [1:0]  stat_clr_bits = '0;
  logic        stat_done, stat_err, irq;
  logic        tx_valid, tx_last;
  logic        tx_ready = 1'b1;
  logic [2:0]  tx_buf;
  logic [10:0] tx_off;
  logic [3:0]  ring_idx;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit stall_mode = 1'b0;
  logic [14:0] exp_q [$];   // {buf, off, last}

  always #2.5 clk = ~clk;

  tx_ring_engine u_tx_ring_engine (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_idx(host_wr_idx), .host_wr_desc(host_wr_desc),
    .host_rd_idx(host_rd_idx), .host_rd_desc(host_rd_desc),
    .wake(wake), .imask_wr(imask_wr), .imask_wdata(imask_wdata),
    .stat_clr_wr(stat_clr_wr), .stat_clr_bits(stat_clr_bits),
    .stat_done(stat_done), .stat_err(stat_err), .irq(irq),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_buf(tx_buf),
    .tx_off(tx_off), .tx_last(tx_last), .ring_idx(ring_idx)
  );

  function automatic logic [13:0] mk(bit own, bit sop, bit eop, int len);
    return {own, sop, eop, 11'(len)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sink readiness, changed only on falling edges
  always @(negedge clk) begin
    cyc++;
    tx_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
  end

  // monitor: pops an expected beat for each accepted one
  always @(negedge clk) begin
    #2;
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected beat", {tx_buf, tx_off, tx_last}, 0);
      end else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        check({tx_buf, tx_off, tx_last} == e, "R4/R5 beat buf-off-last",
              {tx_buf, tx_off, tx_last}, e);
      end
    end
  end

  // driver side: expected beats of one well-formed slot
  task automatic push_frame(int slot, int len);
    for (int o = 0; o < len; o++)
      exp_q.push_back({3'(slot & (NB - 1)), 11'(o), o == len - 1});
  endtask

  task automatic host_write(int idx, logic [13:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_idx = 4'(idx); host_wr_desc = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
  endtask

  task automatic set_mask(logic [31:0] m);
    @(negedge clk); imask_wr = 1'b1; imask_wdata = m;
    @(negedge clk); imask_wr = 1'b0;
  endtask

  task automatic clear_stat(logic [1:0] b);
    @(negedge clk); stat_clr_wr = 1'b1; stat_clr_bits = b;
    @(negedge clk); stat_clr_wr = 1'b0;
  endtask

  task automatic read_desc(int idx, output logic [13:0] d);
    host_rd_idx = 4'(idx);
    #0.5;
    d = host_rd_desc;
  endtask

  task automatic wait_idle(int exp_idx, string req);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!tx_valid && ring_idx == 4'(exp_idx) && exp_q.size() == 0) break;
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, {req, " all expected beats sent"}, exp_q.size(), 0);
    check(ring_idx == 4'(exp_idx), {req, " resting index"}, ring_idx, exp_idx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R4 actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [13:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check(tx_valid == 0, "R2 tx_valid", tx_valid, 0);
    check(ring_idx == 0, "R2 ring_idx", ring_idx, 0);
    check({stat_done, stat_err, irq} == 0, "R2 status/irq", {stat_done, stat_err, irq}, 0);
    read_desc(5, d);
    check(d == 0, "R2 slot clear", d, 0);

    // R3 owned slot without wake stays untouched
    host_write(0, mk(1, 1, 1, 3));
    repeat (10) @(negedge clk);
    check(tx_valid == 0 && ring_idx == 0, "R3 no wake no walk", {tx_valid, ring_idx}, 0);
    read_desc(0, d);
    check(d == mk(1, 1, 1, 3), "R3 slot still owned", d, mk(1, 1, 1, 3));

    host_write(1, mk(1, 1, 1, 1));
    host_write(2, mk(1, 1, 1, 2));
    push_frame(0, 3); push_frame(1, 1); push_frame(2, 2);
    pulse_wake();
    wait_idle(3, "R4");
    read_desc(0, d);
    check(d == mk(0, 1, 1, 3), "R1/R6 own cleared fields kept", d, mk(0, 1, 1, 3));
    check(stat_done == 1, "R10 done set", stat_done, 1);
    check(irq == 0, "R11 reset mask suppresses", irq, 0);

    // R11 mask behaviour
    set_mask(32'h0);
    check(irq == 1, "R11 zero mask enables", irq, 1);
    set_mask(32'h4);
    check(irq == 0, "R11 partial mask suppresses", irq, 0);
    set_mask(32'h0);
    // R10 write-one-to-clear, per bit
    clear_stat(2'b10);
    check(stat_done == 1, "R10 zero bit no effect", stat_done, 1);
    clear_stat(2'b01);
    check(stat_done == 0 && irq == 0, "R10 done cleared", {stat_done, irq}, 0);

    // R8 malformed slot skipped, next slot streamed under stalls
    stall_mode = 1'b1;
    host_write(3, mk(1, 1, 0, 5));
    host_write(4, mk(1, 1, 1, 2));
    push_frame(4, 2);
    pulse_wake();
    wait_idle(5, "R8");
    read_desc(3, d);
    check(d == mk(0, 1, 0, 5), "R8 malformed slot returned", d, mk(0, 1, 0, 5));
    check(stat_err == 1, "R8 err set", stat_err, 1);
    clear_stat(2'b11);
    host_write(5, mk(1, 0, 1, 4));
    pulse_wake();
    wait_idle(6, "R8");
    check(stat_err == 1 && stat_done == 0, "R8 err without done", {stat_err, stat_done}, 2);

    // R7 stop at the first slot not owned
    host_write(7, mk(1, 1, 1, 1));
    pulse_wake();
    repeat (20) @(negedge clk);
    check(ring_idx == 6, "R7 rests on unowned slot", ring_idx, 6);
    read_desc(7, d);
    check(d[13] == 1'b1, "R7 later slot untouched", d[13], 1);
    host_write(6, mk(1, 1, 1, 2));
    push_frame(6, 2); push_frame(7, 1);
    pulse_wake();
    wait_idle(8, "R7");

    // R5/R6 wrap across the end with buffer masking
    for (int k = 0; k < 10; k++) begin
      int s;
      s = (8 + k) % RING;
      host_write(s, mk(1, 1, 1, (k % 3) + 1));
      push_frame(s, (k % 3) + 1);
    end
    pulse_wake();
    wait_idle(2, "R6 wrap");
    read_desc(15, d);
    check(d[13] == 1'b0, "R6 last slot returned", d[13], 0);
    stall_mode = 1'b0;

    // R9 zero-length slot
    clear_stat(2'b11);
    host_write(2, mk(1, 1, 1, 0));
    pulse_wake();
    wait_idle(3, "R9");
    read_desc(2, d);
    check(d == mk(0, 1, 1, 0), "R9 empty slot returned", d, mk(0, 1, 1, 0));
    check(stat_done == 1 && stat_err == 0, "R9 done set", {stat_done, stat_err}, 2);
    check(irq == 1, "R11 irq with zero mask", irq, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule